// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer, 9 bits wide, whose write side and read side each run on their own clock. Words pushed on the write clock come out on the read clock in the same order. The depth is a parameter and defaults to 64 entries, which must be a power of two. Four active-low status flags report the fill level. The empty and almost-empty flags belong to the read clock domain. The full and almost-full flags belong to the write clock domain. Each pointer crosses to the other clock as a Gray code through a two-stage synchronizer. Because of that lag, a flag may clear a few cycles late. A flag is never late to warn about a condition that blocks a transfer.

A shared control pin is sampled while reset is held, and it fixes one of two modes. In the first mode the pin acts as a second write enable. In the second mode, pulling the pin low turns the write and read strobes into accesses to the two threshold offsets instead of the data queue. The almost-empty offset comes first, then the almost-full offset. The offsets are written from the low bits of the data input and read back on the data output.

The read data sits in an output register. An active-low output enable either drives that register onto the bus or floats the bus. A companion valid bit shows which of the two is in effect. The threshold offsets are quasi-static: they should be changed only while no data traffic is under way.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, both pointers return to the first storage location. `empty_n` and `aempty_n` are 0, and `full_n` and `afull_n` are 1. After reset, the first word written is the first word read.
- R2: The level of `wen2_ld` is captured on rising edges of both clocks while `rst_n` is low. A 1 selects dual-enable mode and a 0 selects offset mode.
- R3: In dual-enable mode, a word is stored on a rising `wr_clk` only when `wen1_n` is 0 and `wen2_ld` is 1. With `wen2_ld` at 0, nothing is stored and the offsets do not change.
- R4: In offset mode, `wen1_n` at 0 with `wen2_ld` at 1 stores a data word on a rising `wr_clk`.
- R5: A write attempted while `full_n` is 0 is dropped, so the fill level never exceeds DEPTH. A read attempted while `empty_n` is 0 is dropped, and the output register keeps its value.
- R6: A word is popped on a rising `rd_clk` only when `ren1_n` and `ren2_n` are both 0. That word is in the output register after that same edge. Words leave in the order they were written.
- R7: `empty_n` is 0 exactly when the read-side fill count is zero. `full_n` is 0 exactly when the write-side fill count equals DEPTH. Each pointer moves as a Gray code, one bit per step.
- R8: `aempty_n` is 0 when the fill level is less than or equal to the almost-empty offset. `afull_n` is 0 when the fill level is greater than or equal to DEPTH minus the almost-full offset. Both offsets are 7 after reset.
- R9: In offset mode, each rising `wr_clk` with `wen2_ld` at 0 and `wen1_n` at 0 loads `din[5:0]` into an offset. The loads alternate, almost-empty first after reset, then almost-full. No data word is stored.
- R10: In offset mode, each rising `rd_clk` with `wen2_ld` at 0 and both read enables at 0 places an offset in the output register, zero-extended to 9 bits. The almost-empty offset comes first, then the almost-full offset, alternating. The queue is not popped.
- R11: With `out_en_n` at 1, `dout` is all high-impedance and `dout_valid` is 0. With `out_en_n` at 0, `dout` shows the output register and `dout_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 9 | Write data, or offset value in load cycles |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable, or offset access select (low), according to the strap |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output bus enable, active low |
| dout | output | 9 | Read data or offset readback, high-impedance when disabled |
| dout_valid | output | 1 | High while `dout` is driven |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read-clock domain |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| afull_n | output | 1 | Almost-full flag, active low, write-clock domain |

## Verification
The hardest states to reach are the exact threshold edges: one word either side of each offset, and a buffer that is completely full while writes keep arriving. The synchronizer lag makes the flags at those points depend on when they are sampled. The stimulus reaches them with directed fills of counted length, followed by a settling wait of several cycles on both clocks before the flags are compared. It also runs a write-heavy random phase on the faster write clock, which drives the buffer into full repeatedly, and a read-heavy phase that starves it. The same sequence is repeated in offset mode, with loaded offsets that differ from the defaults.

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DW     = 9,
  parameter int DEPTH  = 64,
  parameter int DEF_AE = 7,
  parameter int DEF_AF = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          out_en_n,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          full_n,
  output logic          afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b = g;
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_w1, rg_w2, wg_r1, wg_r2;
  logic [PW-1:0] wcount, rcount;
  logic [AW-1:0] ae_off, af_off;
  logic [DW-1:0] q;
  logic          mode_w, mode_r;
  logic          sel_w, sel_r;
  logic          full, empty, wr_req, wr_do, ld_wr, rd_req, rb_req, rd_do;

  // strap capture: 1 selects offset mode
  always_ff @(posedge wr_clk) if (!rst_n) mode_w <= !wen2_ld;
  always_ff @(posedge rd_clk) if (!rst_n) mode_r <= !wen2_ld;

  // write domain
  assign wcount = wbin - g2b(rg_w2);
  assign full   = (wcount == FULL_CNT);
  assign wr_req = !wen1_n && wen2_ld;
  assign wr_do  = wr_req && !full;
  assign ld_wr  = mode_w && !wen1_n && !wen2_ld;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rg_w1  <= '0;
      rg_w2  <= '0;
      sel_w  <= 1'b0;
      ae_off <= AW'(DEF_AE);
      af_off <= AW'(DEF_AF);
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (wr_do) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      if (ld_wr) begin
        if (sel_w) af_off <= din[AW-1:0];
        else       ae_off <= din[AW-1:0];
        sel_w <= !sel_w;
      end
    end
  end

  always_ff @(posedge wr_clk) if (wr_do) mem[wbin[AW-1:0]] <= din;

  assign full_n  = !full;
  assign afull_n = wcount < (FULL_CNT - PW'(af_off));

  // read domain
  assign rcount = g2b(wg_r2) - rbin;
  assign empty  = (rcount == '0);
  assign rd_req = !ren1_n && !ren2_n;
  assign rb_req = mode_r && !wen2_ld && rd_req;
  assign rd_do  = rd_req && !rb_req && !empty;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_r1 <= '0;
      wg_r2 <= '0;
      sel_r <= 1'b0;
      q     <= '0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (rd_do) begin
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
        q     <= mem[rbin[AW-1:0]];
      end
      if (rb_req) begin
        q     <= sel_r ? DW'(af_off) : DW'(ae_off);
        sel_r <= !sel_r;
      end
    end
  end

  assign empty_n    = !empty;
  assign aempty_n   = rcount > PW'(ae_off);
  assign dout       = out_en_n ? {DW{1'bz}} : q;
  assign dout_valid = !out_en_n;

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n) wcount <= FULL_CNT); // R5
  AST_NO_UNDERRUN: assert property (@(posedge rd_clk) disable iff (!rst_n) rcount <= FULL_CNT); // R5
  AST_FULL_BLOCKS: assert property (@(posedge wr_clk) disable iff (!rst_n) (full && wr_req) |=> $stable(wbin)); // R5
  AST_EMPTY_BLOCKS: assert property (@(posedge rd_clk) disable iff (!rst_n) empty |=> $stable(rbin)); // R5
  AST_READBACK_NO_POP: assert property (@(posedge rd_clk) disable iff (!rst_n) rb_req |=> $stable(rbin)); // R10
  AST_LOAD_NO_PUSH: assert property (@(posedge wr_clk) disable iff (!rst_n) ld_wr |=> $stable(wbin)); // R9
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n) $countones(wgray ^ $past(wgray)) <= 1); // R7
  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n) $countones(rgray ^ $past(rgray)) <= 1); // R7
  AST_FULL_IN_AF: assert property (@(posedge wr_clk) disable iff (!rst_n) !full_n |-> !afull_n); // R8
  AST_EMPTY_IN_AE: assert property (@(posedge rd_clk) disable iff (!rst_n) !empty_n |-> !aempty_n); // R8
endmodule

// File: tb/dcfifo_pflag_tb_top.sv
`timescale 1ns/100ps
module dcfifo_pflag_tb_top;
  localparam int DEPTH = 64;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [8:0] din = '0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, out_en_n = 1;
  logic [8:0] dout;
  logic dout_valid, empty_n, aempty_n, full_n, afull_n;

  int errs = 0, nchk = 0;
  int ae_m = 7, af_m = 7;
  logic [8:0] mq [$];

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  dcfifo_pflag dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .out_en_n(out_en_n), .dout(dout), .dout_valid(dout_valid),
    .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
  );

  function automatic int exp_ae(int n, int off); return (n > off) ? 1 : 0; endfunction
  function automatic int exp_af(int n, int off); return (n < DEPTH - off) ? 1 : 0; endfunction

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 0; wen2_ld = strap; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    chk("R1 empty_n in reset", empty_n, 0);
    chk("R1 aempty_n in reset", aempty_n, 0);
    chk("R1 full_n in reset", full_n, 1);
    chk("R1 afull_n in reset", afull_n, 1);
    rst_n = 1; wen2_ld = 1;
    mq.delete(); ae_m = 7; af_m = 7;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic check_flags(input string rq);
    int n;
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
    n = mq.size();
    chk({rq, " empty_n"}, empty_n, (n != 0) ? 1 : 0);
    chk({rq, " aempty_n"}, aempty_n, exp_ae(n, ae_m));
    @(negedge wr_clk);
    chk({rq, " full_n"}, full_n, (n != DEPTH) ? 1 : 0);
    chk({rq, " afull_n"}, afull_n, exp_af(n, af_m));
  endtask

  task automatic wr_word(input logic [8:0] d);
    @(negedge wr_clk);
    din = d; wen1_n = 0; wen2_ld = 1;
    if (full_n) mq.push_back(d);
    @(negedge wr_clk);
    wen1_n = 1;
  endtask

  task automatic rd_word(output bit v);
    logic [8:0] e;
    e = '0;
    @(negedge rd_clk);
    ren1_n = 0; ren2_n = 0;
    v = empty_n;
    if (v) e = mq.pop_front();
    @(negedge rd_clk);
    ren1_n = 1; ren2_n = 1;
    if (v) chk("R6 read order", dout, e);
  endtask

  task automatic drain();
    bit v;
    while (mq.size() > 0) rd_word(v);
  endtask

  task automatic readback();
    @(negedge rd_clk);
    wen2_ld = 0; ren1_n = 0; ren2_n = 0;
    @(negedge rd_clk);
    chk("R10 readback almost-empty offset", dout, ae_m);
    @(negedge rd_clk);
    chk("R10 readback almost-full offset", dout, af_m);
    ren1_n = 1; ren2_n = 1; wen2_ld = 1;
  endtask

  task automatic rand_phase(input int cycles, input int wpct, input int rpct, input bit dual);
    fork
      begin
        for (int c = 0; c < cycles; c++) begin
          bit w, e2;
          @(negedge wr_clk);
          w  = ($urandom % 100) < wpct;
          e2 = dual ? (($urandom % 4) != 0) : 1'b1;
          din = 9'($urandom);
          wen1_n = !w; wen2_ld = e2;
          if (w && e2 && full_n) mq.push_back(din);
        end
        @(negedge wr_clk);
        wen1_n = 1; wen2_ld = 1;
      end
      begin
        bit pend;
        logic [8:0] pe;
        pend = 0; pe = '0;
        for (int c = 0; c < cycles; c++) begin
          bit r1, r2;
          @(negedge rd_clk);
          if (pend) chk("R6 random read order", dout, pe);
          r1 = ($urandom % 100) < rpct + 10;
          r2 = ($urandom % 100) < 90;
          ren1_n = !r1; ren2_n = !r2;
          pend = r1 && r2 && empty_n;
          if (pend) pe = mq.pop_front();
        end
        @(negedge rd_clk);
        if (pend) chk("R6 random read order", dout, pe);
        ren1_n = 1; ren2_n = 1;
      end
    join
  endtask

  initial begin
    #1200000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    bit v;
    logic [8:0] held;
    void'($urandom(32'd2024));

    // dual-enable mode
    do_reset(1'b1);
    @(negedge rd_clk);
    chk("R11 bus floats when disabled", (dout === 9'bz) ? 1 : 0, 1);
    chk("R11 valid low when disabled", dout_valid, 0);
    out_en_n = 0;
    @(negedge rd_clk);
    chk("R11 bus driven when enabled", (dout === 9'bz) ? 0 : 1, 1);
    chk("R11 valid high when enabled", dout_valid, 1);

    for (int i = 0; i < 7; i++) wr_word(9'(16 + i));
    check_flags("R8 seven words");
    wr_word(9'h0aa);
    check_flags("R8 eight words");
    rd_word(v);
    chk("R1 first word after reset", dout, 16);
    drain();
    check_flags("R7 drained");

    held = dout;
    rd_word(v);
    chk("R5 read on empty ignored", v, 0);
    chk("R5 output held on empty read", dout, held);

    @(negedge wr_clk);
    wen1_n = 0; wen2_ld = 0; din = 9'h003;
    @(negedge wr_clk);
    wen1_n = 1; wen2_ld = 1;
    check_flags("R3 second enable low stores nothing");

    for (int i = 0; i < 56; i++) wr_word(9'(i * 3));
    check_flags("R8 below almost-full");
    wr_word(9'h155);
    check_flags("R8 at almost-full");
    for (int i = 0; i < 10; i++) wr_word(9'(300 + i));
    chk("R5 model capped at depth", mq.size(), DEPTH);
    check_flags("R5 full, extra writes dropped");
    drain();
    check_flags("R7 empty after full drain");

    rand_phase(3000, 85, 20, 1'b1);
    drain();
    check_flags("R3 after write-heavy random");
    rand_phase(2500, 25, 80, 1'b1);
    drain();
    check_flags("R7 after read-heavy random");

    // offset mode
    do_reset(1'b0);
    wr_word(9'h101);
    wr_word(9'h102);
    readback();
    rd_word(v);
    chk("R10 readback did not pop", dout, 9'h101);
    drain();

    @(negedge wr_clk);
    wen2_ld = 0; wen1_n = 0; din = 9'd3;
    @(negedge wr_clk);
    din = 9'd10;
    @(negedge wr_clk);
    wen1_n = 1; wen2_ld = 1;
    ae_m = 3; af_m = 10;
    check_flags("R9 load stores no data");
    readback();

    for (int i = 0; i < 3; i++) wr_word(9'(40 + i));
    check_flags("R9 loaded almost-empty edge");
    wr_word(9'h077);
    check_flags("R4 offset-mode write above edge");
    for (int i = 0; i < 49; i++) wr_word(9'(i + 100));
    check_flags("R9 below loaded almost-full");
    wr_word(9'h0ee);
    check_flags("R9 at loaded almost-full");
    drain();

    rand_phase(3000, 85, 20, 1'b0);
    drain();
    check_flags("R4 after write-heavy random");
    rand_phase(2500, 25, 80, 1'b0);
    drain();
    check_flags("R2 offset mode kept");
    readback();

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule